// File: doc/BRIEF.md
# Paired Sum/Difference Butterfly Unit

This unit executes a single butterfly instruction against an external 16-entry register file of 16-bit signed values. One instruction reads two source registers, forms both their sum and their difference in the same cycle, and writes the two results to two destination registers. The two source fields are only two bits wide each. The first operand always comes from the low bank (registers 8 to 11) and the second from the high bank (registers 12 to 15), so both fit in a short instruction word. The destination fields are full 4-bit register numbers.

The unit presents two combinational read indices to the register file and takes the read data back in the same cycle. The results are registered and appear on a two-result write port on the clock edge after the instruction is accepted. An encoding with the operand banks swapped, or any other opcode, is flagged as illegal and writes nothing.

Top module: `bfly_unit`

Instruction word, most significant bit first: opcode [15:13], bank-order bit [12], first-source select [11:10], second-source select [9:8], sum destination [7:4], difference destination [3:0].

## Requirements
- R1: While reset is asserted and after its release with no instruction, `wr_sum_en_o`, `wr_diff_en_o`, `ovf_o` and `illegal_o` are 0.
- R2: A legal instruction has opcode 3'b101 and bank-order bit 0. If it is accepted with `instr_valid_i` high, then on the next edge `wr_diff_en_o` is 1. At the same edge `wr_sum_data_o` = A+B and `wr_diff_data_o` = A−B, both wrapped to 16 bits. The index outputs carry the destination fields.
- R3: In the cycle an instruction is presented, `rd_a_idx_o` = 8 + first-source select and `rd_b_idx_o` = 12 + second-source select.
- R4: A valid instruction with bank-order bit 1 sets `illegal_o` on the next edge and asserts neither write enable.
- R5: A valid instruction whose opcode is not 3'b101 sets `illegal_o` on the next edge and asserts neither write enable.
- R6: When both destination fields are equal, only the difference is written: `wr_sum_en_o` stays 0 and `wr_diff_en_o` is 1.
- R7: `ovf_o` is 1 on the commit edge of a legal instruction whose sum or difference falls outside the 16-bit signed range. It is 0 otherwise, and the data still wraps.
- R8: A cycle with `instr_valid_i` low produces no write and no illegal flag on the next edge.
- R9: Instructions on consecutive cycles each commit one edge later. An instruction may read a register written by the previous one, because that write reaches the register file before the next instruction is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction strobe |
| instr_i | input | 16 | Instruction word |
| rd_a_idx_o | output | 4 | First-source register index |
| rd_a_data_i | input | 16 | First-source read data |
| rd_b_idx_o | output | 4 | Second-source register index |
| rd_b_data_i | input | 16 | Second-source read data |
| wr_sum_en_o | output | 1 | Sum write enable |
| wr_sum_idx_o | output | 4 | Sum destination register |
| wr_sum_data_o | output | 16 | Sum value |
| wr_diff_en_o | output | 1 | Difference write enable |
| wr_diff_idx_o | output | 4 | Difference destination register |
| wr_diff_data_o | output | 16 | Difference value |
| ovf_o | output | 1 | Signed overflow on either result |
| illegal_o | output | 1 | Illegal encoding flag |

## Verification
The assertions assume that `instr_valid_i` and `instr_i` carry known values after reset. They also assume that the read data returned for the two indices is settled within the cycle they are presented in. The bench drives these as continuous reads from its own register array. It changes the instruction only on the falling edge and applies each committed write to that array before the next instruction is presented. This keeps the combinational read path stable around every rising edge.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int REG_W   = 4;
  localparam int SEL_W   = 2;
  localparam int OP_W    = 3;
  localparam int BANK_W  = REG_W - SEL_W;
  localparam int INSTR_W = OP_W + 1 + 2*SEL_W + 2*REG_W;

  localparam logic [OP_W-1:0]   OP_BFLY = 3'b101;
  localparam logic [BANK_W-1:0] BANK_A  = 2'b10;  // regs 8..11
  localparam logic [BANK_W-1:0] BANK_B  = 2'b11;  // regs 12..15

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic             swap;
    logic [SEL_W-1:0] sel_a;
    logic [SEL_W-1:0] sel_b;
    logic [REG_W-1:0] dst_sum;
    logic [REG_W-1:0] dst_diff;
  } instr_t;

  typedef struct packed {
    logic             legal;
    logic             illegal;
    logic [REG_W-1:0] dst_sum;
    logic [REG_W-1:0] dst_diff;
  } dec_t;
endpackage

// File: rtl/bfly_decode.sv
module bfly_decode
  import bfly_pkg::*;
(
  input  logic             vld_i,
  input  instr_t           instr_i,
  output logic [REG_W-1:0] rd_a_idx_o,
  output logic [REG_W-1:0] rd_b_idx_o,
  output dec_t             dec_o
);
  logic ok_enc;

  always_comb begin
    ok_enc          = (instr_i.op == OP_BFLY) && !instr_i.swap;
    rd_a_idx_o      = {BANK_A, instr_i.sel_a};
    rd_b_idx_o      = {BANK_B, instr_i.sel_b};
    dec_o.legal     = vld_i && ok_enc;
    dec_o.illegal   = vld_i && !ok_enc;
    dec_o.dst_sum   = instr_i.dst_sum;
    dec_o.dst_diff  = instr_i.dst_diff;
  end
endmodule

// File: rtl/bfly_alu.sv
module bfly_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic         ovf_o
);
  logic [W:0] s_ext, d_ext;

  always_comb begin
    s_ext  = {a_i[W-1], a_i} + {b_i[W-1], b_i};
    d_ext  = {a_i[W-1], a_i} - {b_i[W-1], b_i};
    sum_o  = s_ext[W-1:0];
    diff_o = d_ext[W-1:0];
    // sign of extended result disagrees with truncated sign -> out of range
    ovf_o  = (s_ext[W] ^ s_ext[W-1]) | (d_ext[W] ^ d_ext[W-1]);
  end
endmodule

// File: rtl/bfly_commit.sv
module bfly_commit
  import bfly_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  dec_t             dec_i,
  input  logic [W-1:0]     sum_i,
  input  logic [W-1:0]     diff_i,
  input  logic             ovf_i,
  output logic             wr_sum_en_o,
  output logic [REG_W-1:0] wr_sum_idx_o,
  output logic [W-1:0]     wr_sum_data_o,
  output logic             wr_diff_en_o,
  output logic [REG_W-1:0] wr_diff_idx_o,
  output logic [W-1:0]     wr_diff_data_o,
  output logic             ovf_o,
  output logic             illegal_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_sum_en_o    <= 1'b0;
      wr_diff_en_o   <= 1'b0;
      ovf_o          <= 1'b0;
      illegal_o      <= 1'b0;
      wr_sum_idx_o   <= '0;
      wr_diff_idx_o  <= '0;
      wr_sum_data_o  <= '0;
      wr_diff_data_o <= '0;
    end else begin
      // equal destinations: difference wins, sum suppressed
      wr_sum_en_o    <= dec_i.legal && (dec_i.dst_sum != dec_i.dst_diff);
      wr_diff_en_o   <= dec_i.legal;
      ovf_o          <= dec_i.legal && ovf_i;
      illegal_o      <= dec_i.illegal;
      wr_sum_idx_o   <= dec_i.dst_sum;
      wr_diff_idx_o  <= dec_i.dst_diff;
      wr_sum_data_o  <= sum_i;
      wr_diff_data_o <= diff_i;
    end
  end

  AST_ILL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_sum_en_o && !wr_diff_en_o)); // R4
  AST_SUM_WITH_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sum_en_o |-> wr_diff_en_o); // R2
  AST_DST_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sum_en_o |-> (wr_sum_idx_o != wr_diff_idx_o)); // R6
  AST_OVF_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> wr_diff_en_o); // R7
endmodule

// File: rtl/bfly_unit.sv
module bfly_unit
  import bfly_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [REG_W-1:0]   rd_a_idx_o,
  input  logic [DATA_W-1:0]  rd_a_data_i,
  output logic [REG_W-1:0]   rd_b_idx_o,
  input  logic [DATA_W-1:0]  rd_b_data_i,
  output logic               wr_sum_en_o,
  output logic [REG_W-1:0]   wr_sum_idx_o,
  output logic [DATA_W-1:0]  wr_sum_data_o,
  output logic               wr_diff_en_o,
  output logic [REG_W-1:0]   wr_diff_idx_o,
  output logic [DATA_W-1:0]  wr_diff_data_o,
  output logic               ovf_o,
  output logic               illegal_o
);
  dec_t              dec;
  logic [DATA_W-1:0] sum_c, diff_c;
  logic              ovf_c;

  bfly_decode u_dec (
    .vld_i      (instr_valid_i),
    .instr_i    (instr_t'(instr_i)),
    .rd_a_idx_o (rd_a_idx_o),
    .rd_b_idx_o (rd_b_idx_o),
    .dec_o      (dec)
  );

  bfly_alu #(.W(DATA_W)) u_alu (
    .a_i    (rd_a_data_i),
    .b_i    (rd_b_data_i),
    .sum_o  (sum_c),
    .diff_o (diff_c),
    .ovf_o  (ovf_c)
  );

  bfly_commit #(.W(DATA_W)) u_cmt (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .dec_i          (dec),
    .sum_i          (sum_c),
    .diff_i         (diff_c),
    .ovf_i          (ovf_c),
    .wr_sum_en_o    (wr_sum_en_o),
    .wr_sum_idx_o   (wr_sum_idx_o),
    .wr_sum_data_o  (wr_sum_data_o),
    .wr_diff_en_o   (wr_diff_en_o),
    .wr_diff_idx_o  (wr_diff_idx_o),
    .wr_diff_data_o (wr_diff_data_o),
    .ovf_o          (ovf_o),
    .illegal_o      (illegal_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> (!wr_diff_en_o && !wr_sum_en_o && !illegal_o)); // R8
  AST_VALID_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i |=> (wr_diff_en_o ^ illegal_o)); // R2
endmodule

// File: tb/sim_bfly_unit.sv
module sim_bfly_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  ra, rb, ws_idx, wd_idx;
  logic [15:0] ws_data, wd_data;
  logic        ws_en, wd_en, ovf, ill;
  logic [15:0] rf [16];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bfly_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_i(instr),
    .rd_a_idx_o(ra), .rd_a_data_i(rf[ra]), .rd_b_idx_o(rb), .rd_b_data_i(rf[rb]),
    .wr_sum_en_o(ws_en), .wr_sum_idx_o(ws_idx), .wr_sum_data_o(ws_data),
    .wr_diff_en_o(wd_en), .wr_diff_idx_o(wd_idx), .wr_diff_data_o(wd_data),
    .ovf_o(ovf), .illegal_o(ill)
  );

  function automatic logic [15:0] mk(input int op, input int sw, input int sa,
                                      input int sb, input int ds, input int dd);
    return {op[2:0], sw[0], sa[1:0], sb[1:0], ds[3:0], dd[3:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock of the reference model: drive, predict, compare, update register array
  task automatic step(input bit v, input logic [15:0] ins, input string ctx);
    int a, b, s, d, sa, sb, ds, dd;
    bit legal, bad, e_sen, e_ovf;
    string tag;
    @(negedge clk);
    valid = v; instr = ins;
    sa = int'(ins[11:10]); sb = int'(ins[9:8]);
    ds = int'(ins[7:4]);   dd = int'(ins[3:0]);
    legal = v && ins[15:13] == 3'b101 && !ins[12];
    bad   = v && !legal;
    a = int'($signed(rf[8+sa])); b = int'($signed(rf[12+sb]));
    s = a + b; d = a - b;
    e_ovf = legal && (s > 32767 || s < -32768 || d > 32767 || d < -32768);
    e_sen = legal && ds != dd;
    if (!v) tag = "R8";
    else if (bad) tag = ins[12] ? "R4" : "R5";
    else if (ds == dd) tag = "R6";
    else if (e_ovf) tag = "R7";
    else tag = "R2";
    tag = {tag, " ", ctx};
    #1;
    if (v) chk(ra == 4'(8+sa) && rb == 4'(12+sb), {"R3 ", ctx},
               longint'({ra, rb}), longint'({4'(8+sa), 4'(12+sb)}));
    @(posedge clk); #1;
    chk({ws_en, wd_en, ill, ovf} == {e_sen, legal, bad, e_ovf}, tag,
        longint'({ws_en, wd_en, ill, ovf}), longint'({e_sen, legal, bad, e_ovf}));
    if (legal) begin
      chk(wd_data == 16'(d) && wd_idx == 4'(dd), tag,
          longint'({wd_idx, wd_data}), longint'({4'(dd), 16'(d)}));
      if (e_sen)
        chk(ws_data == 16'(s) && ws_idx == 4'(ds), tag,
            longint'({ws_idx, ws_data}), longint'({4'(ds), 16'(s)}));
      if (e_sen) rf[ds] = 16'(s);
      rf[dd] = 16'(d);  // difference written last: wins on equal destinations
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 16'(i * 1000 - 7000);
    repeat (3) @(posedge clk);
    #1 chk({ws_en, wd_en, ill, ovf} == 4'b0, "R1 in reset", longint'({ws_en, wd_en, ill, ovf}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk({ws_en, wd_en, ill, ovf} == 4'b0, "R1 after release", longint'({ws_en, wd_en, ill, ovf}), 0);

    step(1, mk(5, 0, 0, 0, 1, 2), "basic");
    step(1, mk(5, 0, 3, 2, 4, 5), "other sels");
    step(0, mk(5, 0, 1, 1, 6, 7), "idle with fields");
    step(1, mk(5, 1, 1, 1, 0, 3), "swapped banks");
    step(1, mk(3, 0, 1, 1, 0, 3), "bad opcode");
    step(1, mk(0, 0, 2, 3, 0, 3), "zero opcode");
    step(1, mk(5, 0, 2, 1, 6, 6), "same dst");
    rf[8] = 16'sd32000; rf[12] = 16'sd1000;
    step(1, mk(5, 0, 0, 0, 1, 2), "sum overflow");
    rf[9] = -16'sd32000; rf[13] = 16'sd1000;
    step(1, mk(5, 0, 1, 1, 1, 2), "diff overflow");
    rf[10] = 16'h8000; rf[14] = 16'h8000;
    step(1, mk(5, 0, 2, 2, 3, 4), "min plus min");
    // R9: back-to-back chain, each result feeds the next instruction
    rf[8] = 16'd5; rf[12] = 16'd3;
    step(1, mk(5, 0, 0, 0, 8, 12), "R9 chain 1");
    step(1, mk(5, 0, 0, 0, 8, 12), "R9 chain 2");
    step(1, mk(5, 0, 0, 0, 8, 12), "R9 chain 3");
    step(1, mk(5, 0, 0, 0, 12, 12), "R9 chain same dst");
    for (int k = 0; k < 60; k++)
      step(($urandom % 4) != 0, 16'($urandom), "random");
    step(0, 16'h0, "drain");
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule